// File: doc/BRIEF.md
# Serial GPIO Expander Shift Engine

The block extends a chip's general-purpose pins through a chain of external shift registers. It uses four wires: serial data out, serial data in, a shift clock and a load/shift strobe. Up to eight output bytes are shifted into serial-in/parallel-out registers and latched there. Up to eight input bytes are parallel-loaded into parallel-in/serial-out registers and shifted back. Once enabled in continuous scan mode, the engine repeats this exchange with no further attention.

A small byte-wide register file holds the settings. It has a register for the port counts in each direction, a clock-setup register, a control register, and one write-data and one read-data byte per port. Captured inputs reach the read-data bytes all at once, at the end of a complete scan. A one-cycle `scan_done` pulse marks that moment.

Top module: `sgx_expander`

## Requirements
- R1: After reset the shift clock is low, the strobe is high, serial data out is low, `scan_done` is low and every register reads 0.
- R2: Write-data bytes sit at offsets 0x00+p, read-data bytes at 0x08+p, control at 0x28, clock setup at 0x2A and port count at 0x2B. Write-data, control, clock-setup and port-count bytes read back exactly as written. Writes to 0x08–0x0F are ignored, and unmapped offsets read 0.
- R3: Scanning runs only while control bit 7 is 1 and control bits 2:1 equal 2'b10. Otherwise the shift clock rests at its inactive level and no strobe is issued. Register writes are still accepted in that state.
- R4: A scan is one strobe slot, then 8×max(out ports, in ports) shift-clock pulses, then a second strobe slot. One idle bus cycle follows before the next scan.
- R5: Output bits leave highest port first, bit 7 first. When more input ports than output ports are set, zero padding comes before them. After the closing strobe, output port p holds write-data byte p.
- R6: The first bit received is bit 7 of the highest input port. Input port p ends up in read-data byte p.
- R7: Read-data bytes change only in the cycle where `scan_done` is high for exactly one cycle. Read-data bytes of ports at or above the input count keep their values.
- R8: Clock-setup bits 3:0 choose the shift-clock period in bus cycles: 0x0→1024, 0x5→32, 0x6→16, 0x7→8, 0xC→4, 0xD→3, 0xE→2. Any other code gives 1024.
- R9: Clock-setup bit 4 set makes the shift clock idle high, with the falling edge active. Bit 5 clear makes the strobe active low, and bit 5 set makes it active high.
- R10: A port count above 8 in either nibble of 0x2B (outputs in bits 7:4, inputs in bits 3:0) acts as 8.
- R11: Write-data bytes are sampled once, in the bus cycle a scan starts. A write landing in that same cycle goes out only in the following scan.
- R12: Clearing the enable mid-scan returns both lines to idle on the next cycle, with no `scan_done` and no read-data update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register offset |
| bus_wdata | input | 8 | Register write byte |
| bus_rdata | output | 8 | Register read byte for `bus_addr` (combinational) |
| sio_dout | output | 1 | Serial data to output chain |
| sio_din | input | 1 | Serial data from input chain |
| sio_clk | output | 1 | Shift clock |
| sio_load | output | 1 | Load/shift strobe |
| scan_done | output | 1 | One-cycle end-of-scan pulse |

## Verification
Two events can share a single bus cycle: a bus write to a write-data byte, and the scan start that samples those bytes. The bench enables scanning and then writes a new byte in the very next cycle, which is the cycle the engine leaves idle. A bus-functional model of the external chains then shows the old byte in the first latched output and the new byte in the second. A second collision, a register read in the commit cycle, is judged by watching read-data byte 0 cycle by cycle: it must switch exactly when `scan_done` is high.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_LATCH} seq_state_t;

  // Shift-clock period in bus cycles for a 4-bit setup code.
  function automatic logic [DIV_W-1:0] div_of_code(input logic [3:0] code);
    case (code)
      4'h5:    return DIV_W'(32);
      4'h6:    return DIV_W'(16);
      4'h7:    return DIV_W'(8);
      4'hC:    return DIV_W'(4);
      4'hD:    return DIV_W'(3);
      4'hE:    return DIV_W'(2);
      default: return DIV_W'(1024);
    endcase
  endfunction

  // Port count nibble limited to the number of ports built.
  function automatic logic [3:0] clamp_cnt(input logic [3:0] n, input int lim);
    return (int'(n) > lim) ? 4'(lim) : n;
  endfunction
endpackage

// File: rtl/sgx_regs.sv
module sgx_regs #(
  parameter int NPORT  = 8,
  parameter int ADDR_W = 6,
  localparam int BW    = sgx_pkg::BYTE_W,
  localparam int TOT   = NPORT * BW,
  localparam int IW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BW-1:0]     wdata,
  output logic [BW-1:0]     rdata,
  input  logic              commit,
  input  logic [TOT-1:0]    cap_word,
  input  logic [3:0]        in_eff,
  output logic [TOT-1:0]    wd_flat,
  output logic [TOT-1:0]    rd_flat,
  output logic [BW-1:0]     ctrl,
  output logic [BW-1:0]     cfg,
  output logic [BW-1:0]     pcnt
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(6'h28);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(6'h2A);
  localparam logic [ADDR_W-1:0] A_PCNT = ADDR_W'(6'h2B);

  logic [BW-1:0] wd_q [NPORT];
  logic [BW-1:0] rd_q [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wd_q[p] <= '0;
        rd_q[p] <= '0;
      end else begin
        if (wr_en && addr == ADDR_W'(p)) wd_q[p] <= wdata;
        if (commit && 4'(p) < in_eff) rd_q[p] <= cap_word[p*BW +: BW];
      end
    end
    assign wd_flat[p*BW +: BW] = wd_q[p];
    assign rd_flat[p*BW +: BW] = rd_q[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      cfg  <= '0;
      pcnt <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl <= wdata;
      if (addr == A_CFG)  cfg  <= wdata;
      if (addr == A_PCNT) pcnt <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < ADDR_W'(NPORT))
      rdata = wd_q[IW'(addr)];
    else if (addr < ADDR_W'(2 * NPORT))
      rdata = rd_q[IW'(addr - ADDR_W'(NPORT))];
    else if (addr == A_CTRL)
      rdata = ctrl;
    else if (addr == A_CFG)
      rdata = cfg;
    else if (addr == A_PCNT)
      rdata = pcnt;
  end

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rd_flat));
endmodule

// File: rtl/sgx_timer.sv
module sgx_timer #(
  parameter int DIV_W = sgx_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             slot_end,
  output logic             phase_hi,
  output logic             sample_pt
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half      = div >> 1;
  assign slot_end  = run && (cnt >= div - DIV_W'(1));
  assign phase_hi  = cnt >= half;
  assign sample_pt = run && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || slot_end) cnt <= '0;
    else                       cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/sgx_seq.sv
module sgx_seq #(
  parameter int TOT = 64,
  localparam int BCW = $clog2(TOT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           slot_end,
  input  logic           phase_hi,
  input  logic           sample_pt,
  input  logic [BCW-1:0] nbits,
  input  logic [TOT-1:0] tx_load,
  input  logic           ser_din,
  output logic           run,
  output logic           tx_bit,
  output logic           sclk_act,
  output logic           load_act,
  output logic [TOT-1:0] rx_word,
  output logic           commit,
  output logic           scan_done
);
  import sgx_pkg::*;

  seq_state_t     state;
  logic [BCW-1:0] bitn;
  logic [TOT-1:0] tx_sr;
  logic [TOT-1:0] rx_sr;

  assign run      = state != ST_IDLE;
  assign commit   = go && state == ST_LATCH && slot_end;
  assign sclk_act = state == ST_SHIFT && phase_hi;
  assign load_act = state == ST_LOAD || state == ST_LATCH;
  assign tx_bit   = state == ST_SHIFT && tx_sr[TOT-1];
  assign rx_word  = rx_sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitn      <= '0;
      tx_sr     <= '0;
      rx_sr     <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= commit;
      if (!go) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            state <= ST_LOAD;
            tx_sr <= tx_load;
            bitn  <= '0;
          end
          ST_LOAD:
            if (slot_end) state <= (nbits == '0) ? ST_LATCH : ST_SHIFT;
          ST_SHIFT: begin
            if (sample_pt) rx_sr <= {rx_sr[TOT-2:0], ser_din};
            if (slot_end) begin
              tx_sr <= tx_sr << 1;
              bitn  <= bitn + BCW'(1);
              if (bitn == nbits - BCW'(1)) state <= ST_LATCH;
            end
          end
          default:
            if (slot_end) state <= ST_IDLE;
        endcase
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  // R3
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !sclk_act && !load_act);

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SHIFT |-> bitn < nbits);

  // R12
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && !go |=> state == ST_IDLE && !scan_done);
endmodule

// File: rtl/sgx_expander.sv
module sgx_expander #(
  parameter int NPORT  = 8,
  parameter int ADDR_W = 6,
  localparam int BW    = sgx_pkg::BYTE_W,
  localparam int TOT   = NPORT * BW,
  localparam int BCW   = $clog2(TOT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BW-1:0]     bus_wdata,
  output logic [BW-1:0]     bus_rdata,
  output logic              sio_dout,
  input  logic              sio_din,
  output logic              sio_clk,
  output logic              sio_load,
  output logic              scan_done
);
  import sgx_pkg::*;

  logic [TOT-1:0]   wd_flat, rd_flat, out_masked, tx_load, rx_word, rx_al;
  logic [BW-1:0]    ctrl, cfg, pcnt;
  logic [3:0]       out_eff, in_eff, nmax;
  logic [BCW-1:0]   nbits, in_bits;
  logic [DIV_W-1:0] div;
  logic             go, run, commit, slot_end, phase_hi, sample_pt;
  logic             tx_bit, sclk_act, load_act;

  assign go      = ctrl[7] && ctrl[2:1] == 2'b10;
  assign out_eff = clamp_cnt(pcnt[7:4], NPORT);
  assign in_eff  = clamp_cnt(pcnt[3:0], NPORT);
  assign nmax    = (out_eff > in_eff) ? out_eff : in_eff;
  assign nbits   = BCW'(nmax) * BCW'(BW);
  assign in_bits = BCW'(in_eff) * BCW'(BW);
  assign div     = div_of_code(cfg[3:0]);

  for (genvar p = 0; p < NPORT; p++) begin : g_mask
    assign out_masked[p*BW +: BW] = (4'(p) < out_eff) ? wd_flat[p*BW +: BW] : '0;
  end

  assign tx_load = out_masked << (TOT - int'(nbits));
  assign rx_al   = rx_word >> (nbits - in_bits);

  sgx_regs #(.NPORT(NPORT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .commit(commit),
    .cap_word(rx_al), .in_eff(in_eff), .wd_flat(wd_flat),
    .rd_flat(rd_flat), .ctrl(ctrl), .cfg(cfg), .pcnt(pcnt)
  );

  sgx_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div),
    .slot_end(slot_end), .phase_hi(phase_hi), .sample_pt(sample_pt)
  );

  sgx_seq #(.TOT(TOT)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .slot_end(slot_end),
    .phase_hi(phase_hi), .sample_pt(sample_pt), .nbits(nbits),
    .tx_load(tx_load), .ser_din(sio_din), .run(run), .tx_bit(tx_bit),
    .sclk_act(sclk_act), .load_act(load_act), .rx_word(rx_word),
    .commit(commit), .scan_done(scan_done)
  );

  assign sio_dout = tx_bit;
  assign sio_clk  = sclk_act ^ cfg[4];
  assign sio_load = ~load_act ^ cfg[5];
endmodule

// File: tb/sgx_expander_bench.sv
module sgx_expander_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sio_dout, sio_din, sio_clk, sio_load, scan_done;

  always #4 clk = ~clk;

  sgx_expander u_sgx_expander (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sio_dout(sio_dout),
    .sio_din(sio_din), .sio_clk(sio_clk), .sio_load(sio_load),
    .scan_done(scan_done)
  );

  int vectors = 0, fails = 0;

  // external chain model
  logic        pol_c = 1'b0, pol_l = 1'b0;
  logic [63:0] in_load = '0, isr = '0, osr = '0, out_q = '0;
  logic        prev_c = 1'b0, prev_l = 1'b0, prev_sd = 1'b0;
  int          cyc = 0, edges = 0, loads = 0, sd_cnt = 0, last_t = 0, prev_t = 0;
  bit          sd_wide = 1'b0;
  logic [7:0]  wv [8];

  assign sio_din = isr[63];

  always @(posedge clk) begin
    logic ac, al;
    ac = sio_clk ^ pol_c;
    al = (sio_load == pol_l);
    cyc <= cyc + 1;
    if (al) isr <= in_load;
    else if (ac && !prev_c) isr <= isr << 1;
    if (ac && !prev_c) begin
      osr    <= {osr[62:0], sio_dout};
      edges  <= edges + 1;
      prev_t <= last_t;
      last_t <= cyc;
    end
    if (al && !prev_l) loads <= loads + 1;
    if (!al && prev_l) out_q <= osr;
    if (scan_done) sd_cnt <= sd_cnt + 1;
    if (scan_done && prev_sd) sd_wide <= 1'b1;
    prev_c  <= ac;
    prev_l  <= al;
    prev_sd <= scan_done;
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wait_done(input int n);
    int b;
    b = sd_cnt;
    wait (sd_cnt >= b + n);
    @(negedge clk);
  endtask

  task automatic set_pins(input logic [63:0] pins, input int nin);
    in_load = (nin == 0) ? 64'h0 : pins << (64 - nin * 8);
  endtask

  task automatic set_w(input int p, input logic [7:0] d);
    wv[p] = d;
    wr(6'(p), d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1", "sio_clk", 64'(sio_clk), 0);
    chk("R1", "sio_load", 64'(sio_load), 1);
    chk("R1", "sio_dout", 64'(sio_dout), 0);
    chk("R1", "scan_done", 64'(scan_done), 0);
    rd(6'h00, v); chk("R1", "wdata0", 64'(v), 0);
    rd(6'h08, v); chk("R1", "rdata0", 64'(v), 0);
    rd(6'h28, v); chk("R1", "ctrl", 64'(v), 0);
    rd(6'h2B, v); chk("R1", "pcnt", 64'(v), 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    for (int p = 0; p < 8; p++) set_w(p, 8'(8'h05 + 8'h11 * p));
    for (int p = 0; p < 8; p++) begin
      rd(6'(p), v);
      chk("R2", "wdata readback", 64'(v), 64'(wv[p]));
    end
    wr(6'h28, 8'h06); rd(6'h28, v); chk("R2", "ctrl readback", 64'(v), 64'h06);
    wr(6'h2A, 8'h2E); rd(6'h2A, v); chk("R2", "cfg readback", 64'(v), 64'h2E);
    wr(6'h2B, 8'h35); rd(6'h2B, v); chk("R2", "pcnt readback", 64'(v), 64'h35);
    wr(6'h09, 8'hFF); rd(6'h09, v); chk("R2", "rdata write ignored", 64'(v), 0);
    rd(6'h30, v); chk("R2", "unmapped read", 64'(v), 0);
    wr(6'h28, 8'h00);
    wr(6'h2A, 8'h0E);
  endtask

  task automatic t_disabled;
    int e0, l0, s0;
    logic [7:0] v;
    wr(6'h2B, 8'h22);
    foreach (wv[i]) begin end
    for (int k = 0; k < 3; k++) begin
      logic [7:0] c;
      c = (k == 0) ? 8'h04 : (k == 1) ? 8'h82 : 8'h80;
      wr(6'h28, c);
      e0 = edges; l0 = loads; s0 = sd_cnt;
      repeat (100) @(negedge clk);
      chk("R3", "no shift clock when not scanning", 64'(edges - e0), 0);
      chk("R3", "no strobe when not scanning", 64'(loads - l0), 0);
      chk("R3", "no scan_done when not scanning", 64'(sd_cnt - s0), 0);
    end
    set_w(3, 8'h9D);
    rd(6'h03, v);
    chk("R3", "write accepted while idle", 64'(v), 64'h9D);
    wr(6'h28, 8'h00);
  endtask

  task automatic t_asym;
    logic [7:0] v;
    int e0;
    wr(6'h2B, 8'h13);
    set_w(0, 8'hA7);
    set_pins(64'h563412, 3);
    wr(6'h28, 8'h84);
    wait_done(1);
    e0 = edges;
    wait_done(1);
    chk("R4", "pulses per scan 1 out/3 in", 64'(edges - e0), 24);
    repeat (3) @(negedge clk);
    chk("R5", "padded output chain", out_q[23:0], 64'h0000A7);
    rd(6'h08, v); chk("R6", "in port0", 64'(v), 64'h12);
    rd(6'h09, v); chk("R6", "in port1", 64'(v), 64'h34);
    rd(6'h0A, v); chk("R6", "in port2", 64'(v), 64'h56);
    wr(6'h28, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] v, prev;
    int e0;
    wr(6'h2B, 8'h22);
    set_w(0, 8'hA5);
    set_w(1, 8'h3C);
    set_pins(64'h7E81, 2);
    wr(6'h28, 8'h84);
    wait_done(1);
    e0 = edges;
    wait_done(1);
    chk("R4", "pulses per scan 2/2", 64'(edges - e0), 16);
    repeat (3) @(negedge clk);
    chk("R5", "output ports", out_q[15:0], 64'h3CA5);
    rd(6'h08, v); chk("R6", "in port0", 64'(v), 64'h81);
    rd(6'h09, v); chk("R6", "in port1", 64'(v), 64'h7E);
    rd(6'h0A, v); chk("R7", "port above count kept", 64'(v), 64'h56);
    // change inputs in the idle cycle of a scan boundary
    wait (scan_done == 1'b1);
    @(negedge clk);
    set_pins(64'h7E99, 2);
    bus_addr = 6'h08;
    #1 prev = bus_rdata;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      #1;
      if (scan_done) begin
        chk("R7", "read-data before commit", 64'(prev), 64'h81);
        chk("R7", "read-data in commit cycle", 64'(bus_rdata), 64'h99);
        break;
      end
      chk("R7", "read-data stable mid scan", 64'(bus_rdata), 64'h81);
      prev = bus_rdata;
    end
    wr(6'h28, 8'h00);
    chk("R7", "scan_done one cycle wide", 64'(sd_wide), 0);
  endtask

  task automatic t_div;
    logic [3:0] codes [8] = '{4'hE, 4'hD, 4'hC, 4'h7, 4'h6, 4'h5, 4'h0, 4'h3};
    int         divs  [8] = '{2, 3, 4, 8, 16, 32, 1024, 1024};
    int e0;
    wr(6'h2B, 8'h11);
    set_pins(64'hC3, 1);
    for (int k = 0; k < 8; k++) begin
      wr(6'h28, 8'h00);
      wr(6'h2A, {4'h0, codes[k]});
      e0 = edges;
      wr(6'h28, 8'h84);
      wait (edges >= e0 + 3);
      @(negedge clk);
      chk("R8", $sformatf("period code %0h", codes[k]), 64'(last_t - prev_t), 64'(divs[k]));
    end
    wr(6'h28, 8'h00);
    wr(6'h2A, 8'h0E);
  endtask

  task automatic t_pol;
    logic [7:0] v;
    wr(6'h2A, 8'h3E);
    pol_c = 1'b1; pol_l = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "inverted clock idles high", 64'(sio_clk), 1);
    chk("R9", "inverted strobe idles low", 64'(sio_load), 0);
    wr(6'h2B, 8'h11);
    set_w(0, 8'h6B);
    set_pins(64'hD4, 1);
    wr(6'h28, 8'h84);
    wait_done(2);
    repeat (3) @(negedge clk);
    chk("R9", "output with inverted lines", out_q[7:0], 64'h6B);
    rd(6'h08, v); chk("R9", "input with inverted lines", 64'(v), 64'hD4);
    wr(6'h28, 8'h00);
    wr(6'h2A, 8'h0E);
    pol_c = 1'b0; pol_l = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_clamp;
    logic [7:0]  v;
    logic [63:0] exp;
    int e0;
    wr(6'h2B, 8'hF9);
    rd(6'h2B, v); chk("R10", "oversize count readback", 64'(v), 64'hF9);
    for (int p = 0; p < 8; p++) set_w(p, 8'(8'hC1 + 8'h1D * p));
    for (int p = 0; p < 8; p++) exp[p*8 +: 8] = wv[p];
    set_pins(64'h0123456789ABCDEF, 8);
    wr(6'h28, 8'h84);
    wait_done(1);
    e0 = edges;
    wait_done(1);
    chk("R10", "pulses with clamped counts", 64'(edges - e0), 64);
    repeat (3) @(negedge clk);
    chk("R10", "all eight output ports", out_q, exp);
    for (int p = 0; p < 8; p++) begin
      rd(6'(8 + p), v);
      chk("R10", $sformatf("in port%0d", p), 64'(v), 64'(8'(64'h0123456789ABCDEF >> (8 * p))));
    end
    wr(6'h28, 8'h00);
  endtask

  task automatic t_snapshot;
    wr(6'h2B, 8'h10);
    set_w(0, 8'h11);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h28; bus_wdata = 8'h84;
    @(negedge clk);
    bus_addr = 6'h00; bus_wdata = 8'h22;
    @(negedge clk);
    bus_wr = 1'b0;
    wait_done(1);
    repeat (3) @(negedge clk);
    chk("R11", "first scan uses sampled byte", out_q[7:0], 64'h11);
    wait_done(1);
    repeat (3) @(negedge clk);
    chk("R11", "second scan uses new byte", out_q[7:0], 64'h22);
    wr(6'h28, 8'h00);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    int e0, s0;
    wr(6'h2B, 8'h01);
    wr(6'h2A, 8'h00);
    set_pins(64'h3E, 1);
    e0 = edges;
    wr(6'h28, 8'h84);
    wait (edges >= e0 + 3);
    s0 = sd_cnt;
    wr(6'h28, 8'h00);
    @(negedge clk);
    chk("R12", "clock idle after abort", 64'(sio_clk), 0);
    chk("R12", "strobe idle after abort", 64'(sio_load), 1);
    repeat (50) @(negedge clk);
    chk("R12", "no scan_done after abort", 64'(sd_cnt - s0), 0);
    rd(6'h08, v); chk("R12", "read-data untouched", 64'(v), 64'hEF);
    wr(6'h2A, 8'h0E);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_asym();
    t_basic();
    t_div();
    t_pol();
    t_clamp();
    t_snapshot();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog: got timeout expected completed scans");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule